// File: doc/BRIEF.md
# Dual-Channel 1-out-of-2 Coil Interlock Voter

This block is the voting stage that protects a superconducting magnet against a quench. It serves eight coil channels. Channel 0 is the toroidal-field coil and channels 1 to 7 are the poloidal-field coils 1 to 7. Two independent detection systems, A and B, each report a quench alarm and a quench inhibit for every channel. An inhibited system cannot trip its channel. The remaining unmasked alarms are voted one-out-of-two, so a trip from either system is enough to drop that channel's interlock.

Every alarm, inhibit and interlock line is fail-safe: it is high while healthy and low when it is asserting. All inputs first pass through a two-flop synchronizer. A three-sample agreement filter then follows, so a brief glitch cannot cause a trip. A tripped channel stays latched low until a rearm request arrives while both systems show that channel as healthy or inhibited. The block also produces two summary interlocks and a registered status word.

Each channel runs a two-state machine. The state ARMED drives the interlock high. The state TRIPPED drives it low. The transition TRIP_DETECT goes from ARMED to TRIPPED when the filtered vote shows an unmasked alarm. The transition REARM goes from TRIPPED to ARMED when `rearm` is high in a cycle where the filtered vote is clean. In every other case the state holds.

Top module: `coil_trip_voter`

## Requirements
- R1: After `rst_n` is released, every bit of `ilk_n` is 1, `tf_ilk_n` and `pf_ilk_n` are 1, and `status` is 16'h0000.
- R2: An alarm input of 0 requests a trip. An inhibit input of 0 masks the alarm of the same system on that channel. An interlock output of 0 means tripped. Bit i of each input and output vector belongs to channel i.
- R3: An alarm that is held low drops the channel's interlock on the 6th rising edge after it is driven, and not earlier. An alarm low pulse of 1 or 2 clock cycles never trips the channel.
- R4: A persistent unmasked alarm from system A alone, or from system B alone, trips its own channel and no other channel.
- R5: An alarm from a system whose inhibit for that channel is 0 has no effect on that channel's interlock.
- R6: A tripped channel stays tripped after its alarm clears, until `rearm` is high in a clock cycle.
- R7: A `rearm` request leaves a channel tripped while either system still shows an unmasked alarm on it. The request rearms the channel at that clock edge once both systems are healthy or inhibited.
- R8: `tf_ilk_n` follows channel 0's interlock. `pf_ilk_n` is the AND of the interlocks of channels 1 to 7, so it is 0 when any poloidal channel is tripped.
- R9: Bit i of `status[7:0]` is 1 when channel i is tripped. The register lags `ilk_n` by one clock cycle.
- R10: Bit 8+i of `status` is 1 exactly while channel i is inhibited in both systems. It updates 6 rising edges after the second inhibit goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_alarm_n | input | 8 | System A alarms, low = trip request, bit 0 = toroidal |
| a_inhib_n | input | 8 | System A inhibits, low = inhibited |
| b_alarm_n | input | 8 | System B alarms, low = trip request |
| b_inhib_n | input | 8 | System B inhibits, low = inhibited |
| rearm | input | 1 | Synchronous rearm request, high for one or more cycles |
| ilk_n | output | 8 | Per-channel interlocks, low = tripped |
| tf_ilk_n | output | 1 | Toroidal summary interlock |
| pf_ilk_n | output | 1 | Combined poloidal summary interlock |
| status | output | 16 | [7:0] trip flags, [15:8] bypass flags |

## Verification
The filter assertion assumes that each input is held for the cycles the synchronizer needs. It also assumes that reset lasts long enough to fill the pipeline with healthy values. The bench holds reset for several cycles and changes inputs only on falling edges. The latch and rearm assertions take `rearm` to be synchronous to `clk`, so the bench drives it at a falling edge and holds it high for exactly one rising edge. When the bench releases a channel from a double inhibit, it removes the alarms first. This keeps the release from being taken as a new trip.

// File: rtl/voter_pkg.sv
package voter_pkg;
    typedef enum logic {
        CH_ARMED   = 1'b0,
        CH_TRIPPED = 1'b1
    } chan_state_e;

    localparam int unsigned TF_CHANNEL = 0;
endpackage

// File: rtl/vote_cond.sv
module vote_cond #(
    parameter int unsigned WIDTH       = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned HIST = FILT_LEN - 1;

    logic [WIDTH-1:0] sync_r [SYNC_STAGES];
    logic [WIDTH-1:0] hist_r [HIST];
    logic [WIDTH-1:0] filt_r;
    logic [WIDTH-1:0] sync_out;

    assign sync_out = sync_r[SYNC_STAGES-1];

    // Synchronizer chain and sample history, all reset to the healthy level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_r[s] <= '1;
            for (int h = 0; h < HIST; h++) hist_r[h] <= '1;
        end else begin
            sync_r[0] <= din;
            for (int s = 1; s < SYNC_STAGES; s++) sync_r[s] <= sync_r[s-1];
            hist_r[0] <= sync_out;
            for (int h = 1; h < HIST; h++) hist_r[h] <= hist_r[h-1];
        end
    end

    // Agreement filter: a bit moves only when the whole window agrees.
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [FILT_LEN-1:0] window;
            always_comb begin
                window[0] = sync_out[b];
                for (int k = 0; k < HIST; k++) window[k+1] = hist_r[k][b];
            end
            always_ff @(posedge clk) begin
                if (!rst_n)          filt_r[b] <= 1'b1;
                else if (&window)    filt_r[b] <= 1'b1;
                else if (~|window)   filt_r[b] <= 1'b0;
            end
        end
    endgenerate

    assign dout = filt_r;

    generate
        if (FILT_LEN == 3) begin : g_chk3
            // R3: a filtered bit changes only after three agreeing synchronized samples
            assert_glitch_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (((filt_r ^ $past(filt_r)) & (filt_r ^ $past(sync_out, 1))) == '0) &&
                (((filt_r ^ $past(filt_r)) & (filt_r ^ $past(sync_out, 2))) == '0) &&
                (((filt_r ^ $past(filt_r)) & (filt_r ^ $past(sync_out, 3))) == '0));
        end
    endgenerate
endmodule

// File: rtl/vote_chan.sv
module vote_chan
    import voter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vote_ok,
    input  logic rearm,
    output logic ilk_n
);
    chan_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_ARMED:   if (!vote_ok)          state_d = CH_TRIPPED; // TRIP_DETECT
            CH_TRIPPED: if (rearm && vote_ok)  state_d = CH_ARMED;   // REARM
            default:                           state_d = CH_TRIPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CH_ARMED:   ilk_n = 1'b1;
            CH_TRIPPED: ilk_n = 1'b0;
            default:    ilk_n = 1'b0;
        endcase
    end

    // R4: any unmasked alarm seen while armed trips the channel at the next edge
    assert_trip_on_vote_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED && !vote_ok) |=> (state_q == CH_TRIPPED));
    // R6: the trip is held without a rearm request
    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_TRIPPED && !rearm) |=> (state_q == CH_TRIPPED));
    // R7: rearm is refused while an unmasked alarm remains
    assert_rearm_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_TRIPPED && !vote_ok) |=> (state_q == CH_TRIPPED));
endmodule

// File: rtl/coil_trip_voter.sv
module coil_trip_voter
    import voter_pkg::*;
#(
    parameter int unsigned NCH         = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   a_alarm_n,
    input  logic [NCH-1:0]   a_inhib_n,
    input  logic [NCH-1:0]   b_alarm_n,
    input  logic [NCH-1:0]   b_inhib_n,
    input  logic             rearm,
    output logic [NCH-1:0]   ilk_n,
    output logic             tf_ilk_n,
    output logic             pf_ilk_n,
    output logic [2*NCH-1:0] status
);
    localparam int unsigned RAW_W = 4 * NCH;

    logic [RAW_W-1:0] raw_in, clean;
    logic [NCH-1:0]   fa_alarm, fa_inhib, fb_alarm, fb_inhib;
    logic [NCH-1:0]   eff_a, eff_b, vote_ok, bypass;
    logic [2*NCH-1:0] status_q;

    assign raw_in = {b_inhib_n, b_alarm_n, a_inhib_n, a_alarm_n};

    vote_cond #(
        .WIDTH      (RAW_W),
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) i_cond (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (clean)
    );

    assign fa_alarm = clean[0*NCH +: NCH];
    assign fa_inhib = clean[1*NCH +: NCH];
    assign fb_alarm = clean[2*NCH +: NCH];
    assign fb_inhib = clean[3*NCH +: NCH];

    // Inhibit masks its own system, then one-out-of-two vote.
    assign eff_a   = fa_alarm | ~fa_inhib;
    assign eff_b   = fb_alarm | ~fb_inhib;
    assign vote_ok = eff_a & eff_b;
    assign bypass  = ~fa_inhib & ~fb_inhib;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chan
            vote_chan i_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .vote_ok(vote_ok[c]),
                .rearm  (rearm),
                .ilk_n  (ilk_n[c])
            );
        end
    endgenerate

    assign tf_ilk_n = ilk_n[TF_CHANNEL];
    assign pf_ilk_n = &ilk_n[NCH-1:1];

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= {bypass, ~ilk_n};
    end

    assign status = status_q;

    // R9: the trip flags mirror the interlocks one cycle late
    assert_status_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_q[NCH-1:0] == ~$past(ilk_n)));
    // R10: a bypass flag is only raised for a channel whose two inhibits are both active
    assert_bypass_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q[2*NCH-1:NCH] & ($past(fa_inhib) | $past(fb_inhib))) == '0));
endmodule

// File: tb/test_coil_trip_voter.sv
module test_coil_trip_voter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_alarm_n = 8'hFF, a_inhib_n = 8'hFF;
    logic [7:0] b_alarm_n = 8'hFF, b_inhib_n = 8'hFF;
    logic       rearm = 1'b0;
    logic [7:0] ilk_n;
    logic       tf_ilk_n, pf_ilk_n;
    logic [15:0] status;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    always #10 clk = ~clk;

    coil_trip_voter i_coil_trip_voter (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_alarm_n(a_alarm_n),
        .a_inhib_n(a_inhib_n),
        .b_alarm_n(b_alarm_n),
        .b_inhib_n(b_inhib_n),
        .rearm    (rearm),
        .ilk_n    (ilk_n),
        .tf_ilk_n (tf_ilk_n),
        .pf_ilk_n (pf_ilk_n),
        .status   (status)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_rearm();
        @(negedge clk);
        rearm = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rearm = 1'b0;
    endtask

    task automatic t_reset();
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R1 ilk", {8'h0, ilk_n}, 16'h00FF);
        check("R1 summaries", {14'h0, tf_ilk_n, pf_ilk_n}, 16'h0003);
        check("R1 status", status, 16'h0000);
    endtask

    task automatic t_sys_a_latency();
        @(negedge clk);
        a_alarm_n[3] = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R3 no trip before edge 6", {8'h0, ilk_n}, 16'h00FF);
        @(posedge clk);
        @(negedge clk);
        check("R3 R4 trip at edge 6, channel 3 only", {8'h0, ilk_n}, 16'h00F7);
        check("R9 status not yet updated", status, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        check("R9 status trip flag", status, 16'h0008);
        check("R8 pf low, tf high", {14'h0, tf_ilk_n, pf_ilk_n}, 16'h0002);
        a_alarm_n[3] = 1'b1;
        settle();
        check("R6 latched after alarm clears", {8'h0, ilk_n}, 16'h00F7);
        pulse_rearm();
        check("R6 R7 rearm restores", {8'h0, ilk_n}, 16'h00FF);
    endtask

    task automatic t_sys_b_tf();
        @(negedge clk);
        b_alarm_n[0] = 1'b0;
        settle();
        check("R4 system B trips channel 0", {8'h0, ilk_n}, 16'h00FE);
        check("R8 tf low, pf high", {14'h0, tf_ilk_n, pf_ilk_n}, 16'h0001);
        pulse_rearm();
        settle();
        check("R7 rearm refused while alarm active", {8'h0, ilk_n}, 16'h00FE);
        b_alarm_n[0] = 1'b1;
        settle();
        pulse_rearm();
        check("R7 rearm accepted once clean", {8'h0, ilk_n}, 16'h00FF);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        a_alarm_n[5] = 1'b0;
        @(negedge clk);
        a_alarm_n[5] = 1'b1;
        settle();
        check("R3 one-cycle glitch ignored", {8'h0, ilk_n}, 16'h00FF);
        @(negedge clk);
        b_alarm_n[6] = 1'b0;
        repeat (2) @(negedge clk);
        b_alarm_n[6] = 1'b1;
        settle();
        check("R3 two-cycle glitch ignored", {8'h0, ilk_n}, 16'h00FF);
    endtask

    task automatic t_inhibit();
        @(negedge clk);
        a_inhib_n[2] = 1'b0;
        settle();
        a_alarm_n[2] = 1'b0;
        settle();
        check("R5 inhibited alarm has no effect", {8'h0, ilk_n}, 16'h00FF);
        check("R10 single inhibit is not bypass", status, 16'h0000);
        b_inhib_n[2] = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R10 bypass flag not before edge 6", status, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        check("R10 bypass flag set", status, 16'h0400);
        b_alarm_n[2] = 1'b1;
        b_alarm_n[2] = 1'b0;
        settle();
        check("R5 both inhibited, both alarming", {8'h0, ilk_n}, 16'h00FF);
        a_alarm_n[2] = 1'b1;
        b_alarm_n[2] = 1'b1;
        settle();
        a_inhib_n[2] = 1'b1;
        b_inhib_n[2] = 1'b1;
        settle();
        check("R10 bypass cleared", status, 16'h0000);
        check("R5 released cleanly", {8'h0, ilk_n}, 16'h00FF);
    endtask

    task automatic t_multi();
        @(negedge clk);
        a_alarm_n[7] = 1'b0;
        b_alarm_n[1] = 1'b0;
        settle();
        check("R4 two channels from two systems", {8'h0, ilk_n}, 16'h007D);
        check("R9 status two flags", status, 16'h0082);
        check("R8 pf low tf high", {14'h0, tf_ilk_n, pf_ilk_n}, 16'h0002);
        a_alarm_n[7] = 1'b1;
        settle();
        pulse_rearm();
        check("R7 partial rearm, channel 1 held", {8'h0, ilk_n}, 16'h00FD);
        b_alarm_n[1] = 1'b1;
        settle();
        pulse_rearm();
        check("R6 all rearmed", {8'h0, ilk_n}, 16'h00FF);
        check("R2 fail-safe summaries healthy", {14'h0, tf_ilk_n, pf_ilk_n}, 16'h0003);
    endtask

    initial begin
        t_reset();
        t_sys_a_latency();
        t_sys_b_tf();
        t_glitch();
        t_inhibit();
        t_multi();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule